// File: doc/BRIEF.md
# Spread-Spectrum Clock Dither Generator

This block synthesises a square-wave clock from a master clock with a phase accumulator. It lowers the accumulator's step by an offset code that follows a triangle in time, which spreads the energy of the output clock over a band. The offset is only ever subtracted from the nominal step. The output frequency therefore moves downward from its nominal value and never above it. The output is the accumulator's top bit, so high and low times stay balanced whether the dither runs or not.

An input pin turns the dither on. A select bit chooses one of two peak depths: a narrow sweep of about 2 % or a wide sweep of about 4 % of the nominal step. The sweep rate is a fixed number of master cycles, so it scales with the master clock frequency. Removing the enable never makes the offset jump. The running sweep finishes and the offset parks at zero. The select bit is sampled only when a sweep starts from zero.

Top module: `dither_clk_gen`

## Requirements
- R1: The offset rises from 0 to the peak and falls back to 0, one triangle step every HOLD master cycles. The offset value is floor(tri * peak / 2^TRI_W), where tri counts 0..2^TRI_W. Two consecutive offset samples never differ by more than (peak_wide >> TRI_W) + 1.
- R2: The peak offset reached in a sweep is floor(NOM_INC*2/100) when depth_i = 1 (40 at defaults) and floor(NOM_INC*4/100) when depth_i = 0 (81 at defaults).
- R3: With spread_i low and the sweep parked, offset_o stays 0 and every output period is exactly 2^ACC_W / NOM_INC master cycles (32 at defaults).
- R4: Every output period lies between floor(2^ACC_W/NOM_INC) and ceil(2^ACC_W/(NOM_INC - peak)) master cycles. The frequency never exceeds nominal.
- R5: With spread_i held high, the offset reaches its peak once every 2 * 2^TRI_W * HOLD master cycles (256 at defaults).
- R6: Every high time and every low time of clk_o lies between floor(2^(ACC_W-1)/NOM_INC) and ceil(2^(ACC_W-1)/(NOM_INC - peak)) master cycles, whether or not the dither runs.
- R7: When spread_i drops in mid-sweep, the sweep continues to its peak, descends to 0 and stays there, without an offset step larger than the R1 bound.
- R8: depth_i is sampled only when a sweep leaves zero. A change in mid-sweep takes effect at the next sweep.
- R9: While rst_ni is low, offset_o is 0 and clk_o is low.
- R10: Raising spread_i again while parked starts a new sweep from zero within one step period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_i | input | 1 | Dither enable pin |
| depth_i | input | 1 | Depth select: 1 gives the narrow (2 %) sweep, 0 gives the wide (4 %) sweep |
| offset_o | output | OFF_W | Current triangle offset subtracted from the nominal step |
| clk_o | output | 1 | Synthesised output clock |

## Verification
A table walks four settings of enable and depth: narrow, wide, disabled and narrow again. Each setting yields a distinct peak offset and a distinct bound on period and half period, so a swapped depth decode, an additive instead of subtractive offset, or a missing enable gate shows as a wrong maximum or an out-of-band period. Directed runs time the peak-to-peak interval, which separates a wrong prescale from a wrong triangle length. They flip the depth select partway up a sweep to show the old peak persists for one sweep. They drop the enable mid-ramp and confirm the sweep completes smoothly to its peak before parking at an exact nominal period, and that it restarts later.

// File: rtl/dither_pkg.sv
package dither_pkg;
  typedef enum logic {
    SWEEP_DOWN = 1'b0,
    SWEEP_UP   = 1'b1
  } sweep_dir_e;

  typedef enum logic {
    DEPTH_WIDE   = 1'b0,
    DEPTH_NARROW = 1'b1
  } depth_e;
endpackage

// File: rtl/dither_sweep.sv
module dither_sweep
  import dither_pkg::*;
#(
  parameter int unsigned TRI_W = 4,
  parameter int unsigned HOLD  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           spread_i,
  input  logic           depth_i,
  output logic [TRI_W:0] tri_o,
  output depth_e         depth_o
);
  localparam int unsigned TRI_MAX = 1 << TRI_W;
  localparam int unsigned HC_W    = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [TRI_W:0] TRI_TOP   = (TRI_W+1)'(TRI_MAX);
  localparam logic [TRI_W:0] TRI_TOPM1 = (TRI_W+1)'(TRI_MAX - 1);

  logic           step;
  logic [TRI_W:0] tri_q;
  sweep_dir_e     dir_q;
  depth_e         depth_q;

  // prescaler: one triangle step per HOLD master cycles
  generate
    if (HOLD == 1) begin : g_no_pre
      assign step = 1'b1;
    end else begin : g_pre
      logic [HC_W-1:0] hc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hc_q <= '0;
        else if (hc_q == HC_W'(HOLD - 1)) hc_q <= '0;
        else hc_q <= hc_q + 1'b1;
      end
      assign step = (hc_q == HC_W'(HOLD - 1));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tri_q   <= '0;
      dir_q   <= SWEEP_DOWN;
      depth_q <= DEPTH_WIDE;
    end else if (step) begin
      if (tri_q == '0) begin
        // bottom: start a sweep only when enabled, depth captured here
        if (spread_i) begin
          tri_q   <= (TRI_W+1)'(1);
          dir_q   <= SWEEP_UP;
          depth_q <= depth_e'(depth_i);
        end else begin
          dir_q   <= SWEEP_DOWN;
        end
      end else if (dir_q == SWEEP_UP) begin
        if (tri_q == TRI_TOPM1) begin
          tri_q <= TRI_TOP;
          dir_q <= SWEEP_DOWN;
        end else begin
          tri_q <= tri_q + 1'b1;
        end
      end else begin
        tri_q <= tri_q - 1'b1;
      end
    end
  end

  assign tri_o   = tri_q;
  assign depth_o = depth_q;
endmodule

// File: rtl/dither_scale.sv
module dither_scale
  import dither_pkg::*;
#(
  parameter int unsigned TRI_W       = 4,
  parameter int unsigned OFF_W       = 7,
  parameter int unsigned PEAK_NARROW = 40,
  parameter int unsigned PEAK_WIDE   = 81
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TRI_W:0]   tri_i,
  input  depth_e           depth_i,
  output logic [OFF_W-1:0] off_o
);
  localparam int unsigned PROD_W = TRI_W + 1 + OFF_W;

  logic [OFF_W-1:0]  peak_sel;
  logic [PROD_W-1:0] prod;
  logic [OFF_W-1:0]  off_q;

  assign peak_sel = (depth_i == DEPTH_NARROW) ? OFF_W'(PEAK_NARROW) : OFF_W'(PEAK_WIDE);
  assign prod     = PROD_W'(tri_i) * PROD_W'(peak_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= '0;
    else         off_q <= OFF_W'(prod >> TRI_W);
  end

  assign off_o = off_q;
endmodule

// File: rtl/dither_nco.sv
module dither_nco #(
  parameter int unsigned ACC_W   = 16,
  parameter int unsigned NOM_INC = 2048,
  parameter int unsigned OFF_W   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OFF_W-1:0] off_i,
  output logic             clk_o
);
  localparam logic [ACC_W-1:0] NOM_V = ACC_W'(NOM_INC);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc;

  // offset only ever subtracts: frequency moves downward
  assign inc = NOM_V - ACC_W'(off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + inc;
  end

  // top bit gives balanced high and low halves
  assign clk_o = acc_q[ACC_W-1];
endmodule

// File: rtl/dither_clk_gen.sv
module dither_clk_gen
  import dither_pkg::*;
#(
  parameter int unsigned ACC_W      = 16,
  parameter int unsigned NOM_INC    = 2048,
  parameter int unsigned TRI_W      = 4,
  parameter int unsigned HOLD       = 8,
  parameter int unsigned PCT_NARROW = 2,
  parameter int unsigned PCT_WIDE   = 4,
  localparam int unsigned PEAK_NARROW = NOM_INC * PCT_NARROW / 100,
  localparam int unsigned PEAK_WIDE   = NOM_INC * PCT_WIDE / 100,
  localparam int unsigned OFF_W       = $clog2(PEAK_WIDE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spread_i,
  input  logic             depth_i,
  output logic [OFF_W-1:0] offset_o,
  output logic             clk_o
);
  logic [TRI_W:0]   tri_w;
  depth_e           depth_w;
  logic [OFF_W-1:0] off_w;

  dither_sweep #(.TRI_W(TRI_W), .HOLD(HOLD)) u_sweep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .spread_i (spread_i),
    .depth_i  (depth_i),
    .tri_o    (tri_w),
    .depth_o  (depth_w)
  );

  dither_scale #(
    .TRI_W(TRI_W), .OFF_W(OFF_W),
    .PEAK_NARROW(PEAK_NARROW), .PEAK_WIDE(PEAK_WIDE)
  ) u_scale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tri_i   (tri_w),
    .depth_i (depth_w),
    .off_o   (off_w)
  );

  dither_nco #(.ACC_W(ACC_W), .NOM_INC(NOM_INC), .OFF_W(OFF_W)) u_nco (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .off_i  (off_w),
    .clk_o  (clk_o)
  );

  assign offset_o = off_w;
endmodule

// File: rtl/dither_clk_chk.sv
module dither_clk_chk #(
  parameter int unsigned ACC_W     = 16,
  parameter int unsigned NOM_INC   = 2048,
  parameter int unsigned TRI_W     = 4,
  parameter int unsigned PEAK_WIDE = 81,
  parameter int unsigned OFF_W     = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OFF_W-1:0] offset_o,
  input logic             clk_o
);
  localparam int unsigned HALF_SPAN = 1 << (ACC_W - 1);
  localparam int unsigned INC_MIN   = NOM_INC - PEAK_WIDE;
  localparam int unsigned HALF_MIN  = HALF_SPAN / NOM_INC;
  localparam int unsigned HALF_MAX  = (HALF_SPAN + INC_MIN - 1) / INC_MIN;
  localparam int unsigned STEP_MAX  = (PEAK_WIDE >> TRI_W) + 1;

  logic        prev_q;
  logic        seen_q;
  logic [31:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= HALF_MIN;
    end else begin
      prev_q <= clk_o;
      if (clk_o != prev_q) begin
        cnt_q  <= 32'd1;
        seen_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 32'd1;
      end
    end
  end

  a_r2_offset_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(offset_o) <= int'(PEAK_WIDE));

  a_r7_smooth_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(offset_o) >= int'($past(offset_o))) ?
      (int'(offset_o) - int'($past(offset_o))) :
      (int'($past(offset_o)) - int'(offset_o))) <= int'(STEP_MAX));

  a_r4_half_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_o != prev_q) |-> (cnt_q >= HALF_MIN));

  a_r6_half_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && (clk_o != prev_q)) |-> (cnt_q <= HALF_MAX));
endmodule

bind dither_clk_gen dither_clk_chk #(
  .ACC_W(ACC_W), .NOM_INC(NOM_INC), .TRI_W(TRI_W),
  .PEAK_WIDE(PEAK_WIDE), .OFF_W(OFF_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .offset_o (offset_o),
  .clk_o    (clk_o)
);

// File: tb/dither_clk_gen_tb.sv
module dither_clk_gen_tb;
  localparam int ACC_W   = 16;
  localparam int NOM_INC = 2048;
  localparam int TRI_W   = 4;
  localparam int HOLD    = 8;
  localparam int PK_N    = NOM_INC * 2 / 100;
  localparam int PK_W    = NOM_INC * 4 / 100;
  localparam int OFF_W   = $clog2(PK_W + 1);
  localparam int SWEEP   = 2 * (1 << TRI_W) * HOLD;
  localparam int SPAN    = 1 << ACC_W;
  localparam int P_NOM   = SPAN / NOM_INC;
  localparam int STEP_MX = (PK_W >> TRI_W) + 1;
  localparam int NV      = 4;

  // stimulus {spread, depth} and expected peak offset
  localparam logic [1:0] VEC_IN [NV] = '{2'b11, 2'b10, 2'b00, 2'b11};
  localparam int         VEC_PK [NV] = '{PK_N, PK_W, 0, PK_N};

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             spread_i;
  logic             depth_i;
  logic [OFF_W-1:0] offset_o;
  logic             clk_o;

  int checks = 0;
  int errors = 0;
  int max_off, max_step, per_min, per_max, hl_min, hl_max;

  always #4 clk_i = ~clk_i;

  dither_clk_gen #(.ACC_W(ACC_W), .NOM_INC(NOM_INC), .TRI_W(TRI_W), .HOLD(HOLD)) u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .spread_i (spread_i),
    .depth_i  (depth_i),
    .offset_o (offset_o),
    .clk_o    (clk_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  task automatic observe(input int n);
    int  last_rise = -1;
    int  last_edge = -1;
    logic pc;
    int  po;
    max_off = 0; max_step = 0;
    per_min = 1 << 30; per_max = 0;
    hl_min  = 1 << 30; hl_max  = 0;
    pc = clk_o;
    po = int'(offset_o);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (int'(offset_o) > max_off) max_off = int'(offset_o);
      if ((int'(offset_o) - po > max_step)) max_step = int'(offset_o) - po;
      if ((po - int'(offset_o) > max_step)) max_step = po - int'(offset_o);
      po = int'(offset_o);
      if (clk_o != pc) begin
        if (last_edge >= 0) begin
          if (i - last_edge < hl_min) hl_min = i - last_edge;
          if (i - last_edge > hl_max) hl_max = i - last_edge;
        end
        last_edge = i;
        if (clk_o) begin
          if (last_rise >= 0) begin
            if (i - last_rise < per_min) per_min = i - last_rise;
            if (i - last_rise > per_max) per_max = i - last_rise;
          end
          last_rise = i;
        end
      end
      pc = clk_o;
    end
  endtask

  task automatic wait_off(input bit want_zero, input string req);
    int k = 0;
    while (((offset_o == '0) != want_zero) && k < 4 * SWEEP) begin
      @(negedge clk_i);
      k++;
    end
    if (k >= 4 * SWEEP) check(1'b0, req, int'(offset_o), want_zero ? 0 : 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; spread_i = 1'b0; depth_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(offset_o == '0, "R9 offset in reset", int'(offset_o), 0);
    check(clk_o == 1'b0, "R9 clk_o in reset", int'(clk_o), 0);
    rst_ni = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      int pmax, hmax;
      spread_i = VEC_IN[v][1];
      depth_i  = VEC_IN[v][0];
      repeat (2 * SWEEP + 4) @(negedge clk_i);
      observe(2 * SWEEP);
      pmax = ceil_div(SPAN, NOM_INC - VEC_PK[v]);
      hmax = ceil_div(SPAN / 2, NOM_INC - VEC_PK[v]);
      check(max_off == VEC_PK[v], "R2 peak offset", max_off, VEC_PK[v]);
      check(max_step <= STEP_MX, "R1 step size", max_step, STEP_MX);
      check(per_min >= P_NOM, "R4 period min", per_min, P_NOM);
      check(per_max <= pmax, "R4 period max", per_max, pmax);
      check(hl_min >= P_NOM / 2, "R6 half min", hl_min, P_NOM / 2);
      check(hl_max <= hmax, "R6 half max", hl_max, hmax);
      if (!VEC_IN[v][1]) begin
        check(per_min == P_NOM && per_max == P_NOM, "R3 parked period", per_max, P_NOM);
        check(max_off == 0, "R3 parked offset", max_off, 0);
      end
    end

    // R5 sweep rate: interval between peak arrivals
    begin
      int t0 = -1, t1 = -1;
      int po;
      spread_i = 1'b1; depth_i = 1'b0;
      repeat (2 * SWEEP) @(negedge clk_i);
      po = int'(offset_o);
      for (int i = 0; i < 3 * SWEEP && t1 < 0; i++) begin
        @(negedge clk_i);
        if (int'(offset_o) == PK_W && po != PK_W) begin
          if (t0 < 0) t0 = i; else t1 = i;
        end
        po = int'(offset_o);
      end
      check(t1 - t0 == SWEEP, "R5 sweep period", t1 - t0, SWEEP);
    end

    // R8 depth change mid-sweep
    wait_off(1'b1, "R8 reach zero");
    wait_off(1'b0, "R8 leave zero");
    depth_i = 1'b1;
    observe(20 * HOLD);
    check(max_off == PK_W, "R8 old depth kept", max_off, PK_W);
    wait_off(1'b1, "R8 reach zero 2");
    wait_off(1'b0, "R8 leave zero 2");
    observe(20 * HOLD);
    check(max_off == PK_N, "R8 new depth next sweep", max_off, PK_N);

    // R7 disable mid-sweep
    depth_i = 1'b0;
    wait_off(1'b1, "R7 reach zero");
    wait_off(1'b0, "R7 leave zero");
    spread_i = 1'b0;
    observe(40 * HOLD);
    check(max_off == PK_W, "R7 sweep completes", max_off, PK_W);
    check(max_step <= STEP_MX, "R7 no jump", max_step, STEP_MX);
    check(offset_o == '0, "R7 parked", int'(offset_o), 0);
    observe(2 * SWEEP);
    check(max_off == 0, "R3 stays parked", max_off, 0);
    check(per_max == P_NOM, "R3 nominal period", per_max, P_NOM);

    // R10 restart
    spread_i = 1'b1;
    begin
      int k = 0;
      while (offset_o == '0 && k < 3 * HOLD) begin
        @(negedge clk_i);
        k++;
      end
      check(offset_o != '0, "R10 restart", k, 2 * HOLD);
      check(int'(offset_o) <= STEP_MX, "R10 starts from zero", int'(offset_o), STEP_MX);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule